// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block is a byte-wide streaming filter placed on the receive path between the MAC byte stream and the receive FIFO. Each frame arrives with the preamble and start delimiter already removed, one byte per valid cycle, with start and end markers. The frame holds 12 address bytes, a two-byte length/type field, the data, any pad, and the 4-byte frame check sequence (FCS).

When stripping is enabled for a frame and its length/type value is below 46, the block forwards only the 14 header bytes and as many data bytes as the length value says. It drops the pad and the FCS, because the FCS no longer matches the shortened frame. The block decides which bytes to drop as they arrive, so dropped bytes never reach the FIFO. A frame whose value is 46 or more, including any Ethernet type value, goes through unchanged. Kept bytes appear on the output one cycle after they enter.

Top module: `rx_pad_strip`

## Requirements
- R1: With stripping disabled for a frame, every byte of that frame is output one cycle after it enters, with the same data, start and end markers, and out_trunc stays low.
- R2: With stripping enabled and a length/type value of 46 or more (for example 46, 0x0800, 1500), the whole frame is output unmodified, FCS included, with out_trunc low.
- R3: With stripping enabled and a length/type value L below 46, exactly 14 + L bytes are output: the header and the first L data bytes. Pad and FCS bytes are not output.
- R4: The length/type value is taken from frame byte offsets 12 (most significant) and 13 (least significant), counting the first byte as offset 0.
- R5: On a stripped frame, out_eof is asserted with the last kept byte. The input bytes that follow, up to the input end marker, produce no output valid.
- R6: A length value of 0 with stripping enabled outputs only the 14 header bytes, with out_eof on the byte at offset 13.
- R7: If stripping is enabled and the input frame ends before its keep point, either before offset 13 or before byte 13 + L on a short frame, then the last received byte is output with out_eof and out_trunc both high. out_trunc is never high otherwise.
- R8: strip_en is sampled with the start byte of each frame. A change during a frame takes effect on the next frame.
- R9: A synchronous active-high reset clears out_valid, out_eof and out_trunc. After reset, input bytes are ignored until the next start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strip_en | input | 1 | Enable for pad and FCS stripping, sampled at frame start |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| in_data | input | 8 | Input frame byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is the first byte of a frame |
| out_eof | output | 1 | Output byte is the last forwarded byte of a frame |
| out_trunc | output | 1 | Frame ended before its keep point; asserted together with out_eof |
| out_data | output | 8 | Output frame byte |

## Verification
The end marker can come from two sources: the count reaching the last kept byte (13 + L), and the input end marker. These two can fall in the same cycle. This is provoked with a short frame that carries no pad and no FCS, so that its final input byte is exactly byte 13 + L. The bench expects one end marker on that byte, with out_trunc low. A frame that ends one keep point early is also run, and there the bench expects out_trunc. A length of 0, where the keep point falls on the second length byte itself, covers the case where that point coincides with the decode of the length value.

// File: rtl/pad_strip_pkg.sv
package pad_strip_pkg;

    localparam int HDR_BYTES   = 14;
    localparam int LEN_HI_POS  = 12;
    localparam int LEN_LO_POS  = 13;
    localparam int MIN_PAYLOAD = 46;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic       trunc;
        logic [7:0] data;
    } beat_t;

    function automatic logic len_is_short(input logic [15:0] len);
        return len < 16'(MIN_PAYLOAD);
    endfunction

endpackage

// File: rtl/frame_index.sv
module frame_index
    import pad_strip_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strip_en,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_active,
    output logic             cur_en,
    output logic [15:0]      len_field
);

    logic [IDX_W-1:0] cnt_q;
    logic             active_q;
    logic             en_q;
    logic [7:0]       len_hi_q;

    assign cur_active = in_sof | active_q;
    assign cur_idx    = in_sof ? '0 : cnt_q;
    assign cur_en     = in_sof ? strip_en : en_q;
    assign len_field  = {len_hi_q, in_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            en_q     <= 1'b0;
            len_hi_q <= '0;
        end else if (in_valid && cur_active) begin
            active_q <= !in_eof;
            en_q     <= cur_en;
            if (cur_idx != '1)
                cnt_q <= cur_idx + 1'b1;
            if (cur_idx == IDX_W'(LEN_HI_POS))
                len_hi_q <= in_data;
        end
    end

    AST_EN_HELD: assert property (@(posedge clk) disable iff (rst)
        in_valid && cur_active && !in_sof && !in_eof |=> in_sof || cur_en == $past(cur_en)) // R8
        else $error("enable changed inside a frame");

endmodule

// File: rtl/keep_decide.sv
module keep_decide
    import pad_strip_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_eof,
    input  logic             cur_active,
    input  logic             cur_en,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [15:0]      len_field,
    output logic             keep,
    output logic             last,
    output logic             trunc
);

    logic             short_q;
    logic [IDX_W-1:0] limit_q;
    logic             at_lo;
    logic             short_now;
    logic [IDX_W-1:0] limit_now;
    logic             pending;

    assign at_lo     = cur_idx == IDX_W'(LEN_LO_POS);
    assign short_now = cur_en && len_is_short(len_field);
    assign limit_now = IDX_W'(LEN_LO_POS) + IDX_W'(len_field[5:0]);

    always_comb begin
        keep    = 1'b0;
        last    = 1'b0;
        pending = 1'b0;
        if (in_valid && cur_active) begin
            if (cur_idx < IDX_W'(LEN_LO_POS)) begin
                keep    = 1'b1;
                pending = cur_en;
            end else if (at_lo) begin
                keep    = 1'b1;
                last    = short_now && (len_field == 16'd0);
                pending = short_now;
            end else begin
                keep    = !short_q || (cur_idx <= limit_q);
                last    = short_q && (cur_idx == limit_q);
                pending = short_q;
            end
        end
        trunc = keep && in_eof && !last && pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            short_q <= 1'b0;
            limit_q <= '0;
        end else if (in_valid && cur_active && at_lo) begin
            short_q <= short_now;
            limit_q <= limit_now;
        end
    end

    AST_HEADER_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid && cur_active && cur_idx < IDX_W'(HDR_BYTES) |-> keep) // R3
        else $error("header byte dropped");

    AST_LAST_IS_KEPT: assert property (@(posedge clk) disable iff (rst)
        last |-> keep && cur_en) // R5
        else $error("end point on a dropped byte");

endmodule

// File: rtl/rx_pad_strip.sv
module rx_pad_strip
    import pad_strip_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strip_en,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_data,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_trunc,
    output logic [7:0] out_data
);

    logic [IDX_W-1:0] cur_idx;
    logic             cur_active;
    logic             cur_en;
    logic [15:0]      len_field;
    logic             keep;
    logic             last;
    logic             trunc;
    beat_t            out_q;

    frame_index #(.IDX_W(IDX_W)) u_index (
        .clk        (clk),
        .rst        (rst),
        .strip_en   (strip_en),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_data    (in_data),
        .cur_idx    (cur_idx),
        .cur_active (cur_active),
        .cur_en     (cur_en),
        .len_field  (len_field)
    );

    keep_decide #(.IDX_W(IDX_W)) u_keep (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_eof     (in_eof),
        .cur_active (cur_active),
        .cur_en     (cur_en),
        .cur_idx    (cur_idx),
        .len_field  (len_field),
        .keep       (keep),
        .last       (last),
        .trunc      (trunc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= keep;
            out_q.sof   <= keep && in_sof;
            out_q.eof   <= keep && (in_eof || last);
            out_q.trunc <= trunc;
            out_q.data  <= in_data;
        end
    end

    assign out_valid = out_q.valid;
    assign out_sof   = out_q.sof;
    assign out_eof   = out_q.eof;
    assign out_trunc = out_q.trunc;
    assign out_data  = out_q.data;

    AST_EOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_valid) // R5
        else $error("end marker without valid");

    AST_TRUNC_WITH_EOF: assert property (@(posedge clk) disable iff (rst)
        out_trunc |-> out_eof) // R7
        else $error("truncation flag without end marker");

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        in_valid && cur_active && !cur_en |=>
            out_valid && out_data == $past(in_data) && out_eof == $past(in_eof) && !out_trunc) // R1
        else $error("disabled frame altered");

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !out_valid && !out_eof && !out_trunc) // R9
        else $error("output active after reset");

endmodule

// File: tb/rx_pad_strip_test.sv
`timescale 1ns/1ps
module rx_pad_strip_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strip_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_sof, out_eof, out_trunc;
    logic [7:0] out_data;

    always #2.5 clk = ~clk;

    rx_pad_strip uut (
        .clk(clk), .rst(rst), .strip_en(strip_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_trunc(out_trunc), .out_data(out_data)
    );

    typedef struct packed {
        logic        en;
        logic [15:0] len;
        logic [11:0] total;
        logic [11:0] exp_n;
        logic        exp_tr;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b0, 16'd10,    12'd64,   12'd64,   1'b0},
        '{1'b1, 16'd10,    12'd64,   12'd24,   1'b0},
        '{1'b1, 16'd46,    12'd64,   12'd64,   1'b0},
        '{1'b1, 16'h0800,  12'd64,   12'd64,   1'b0},
        '{1'b1, 16'd45,    12'd64,   12'd59,   1'b0},
        '{1'b1, 16'd0,     12'd64,   12'd14,   1'b0},
        '{1'b1, 16'd20,    12'd24,   12'd24,   1'b1},
        '{1'b1, 16'd1500,  12'd1518, 12'd1518, 1'b0},
        '{1'b0, 16'd0,     12'd64,   12'd64,   1'b0},
        '{1'b1, 16'd1,     12'd64,   12'd15,   1'b0},
        '{1'b1, 16'd20,    12'd34,   12'd34,   1'b0},
        '{1'b1, 16'h2D00,  12'd64,   12'd64,   1'b0}
    };

    int checks = 0;
    int errors = 0;
    logic [7:0] sent     [0:2047];
    logic [7:0] mon_data [0:2047];
    int   mon_n = 0;
    int   eof_cnt = 0;
    int   eof_pos = -1;
    logic trunc_seen = 1'b0;
    logic first_sof = 1'b0;
    logic stray_sof = 1'b0;

    function automatic string req_of(input int i);
        case (i)
            0, 8:     return "R1";
            2, 3, 7:  return "R2";
            1, 4:     return "R3";
            5:        return "R6";
            6:        return "R7";
            9, 10:    return "R5";
            default:  return "R4";
        endcase
    endfunction

    function automatic logic [7:0] byte_at(input int k, input logic [15:0] len);
        if (k == 12) return len[15:8];
        if (k == 13) return len[7:0];
        return 8'((k * 37 + 5) ^ (k >> 3));
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (out_valid) begin
            mon_data[mon_n] = out_data;
            if (mon_n == 0) first_sof = out_sof;
            else if (out_sof) stray_sof = 1'b1;
            if (out_eof) begin
                eof_cnt++;
                eof_pos = mon_n;
                trunc_seen = out_trunc;
            end
            mon_n++;
        end
    end

    task automatic clear_mon();
        mon_n = 0; eof_cnt = 0; eof_pos = -1;
        trunc_seen = 1'b0; first_sof = 1'b0; stray_sof = 1'b0;
    endtask

    task automatic send_frame(input logic en, input logic en_after,
                              input logic [15:0] len, input int total, input logic with_sof);
        clear_mon();
        for (int k = 0; k < total; k++) begin
            @(posedge clk); #1;
            strip_en = (k == 0) ? en : en_after;
            in_valid = 1'b1;
            in_sof   = with_sof && (k == 0);
            in_eof   = (k == total - 1);
            in_data  = byte_at(k, len);
            sent[k]  = in_data;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic check_frame(input string tag, input int exp_n, input logic exp_tr);
        int bad = 0;
        chk(mon_n == exp_n, tag, "byte count", mon_n, exp_n);
        for (int k = 0; k < mon_n && k < exp_n; k++)
            if (mon_data[k] !== sent[k]) bad++;
        chk(bad == 0, tag, "data mismatches", bad, 0);
        chk(eof_cnt == 1 && eof_pos == exp_n - 1, tag, "end marker position", eof_pos, exp_n - 1);
        chk(trunc_seen == exp_tr, tag, "truncation flag", int'(trunc_seen), int'(exp_tr));
        chk(first_sof && !stray_sof, tag, "start marker", int'(first_sof), 1);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual %0d expected below 150000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !out_eof && !out_trunc, "R9", "idle during reset",
            int'(out_valid), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (2) @(posedge clk);

        for (int i = 0; i < NVEC; i++) begin
            send_frame(VECS[i].en, VECS[i].en, VECS[i].len, int'(VECS[i].total), 1'b1);
            check_frame(req_of(i), int'(VECS[i].exp_n), VECS[i].exp_tr);
        end

        // R8: enable changes after the start byte
        send_frame(1'b1, 1'b0, 16'd10, 64, 1'b1);
        check_frame("R8", 24, 1'b0);
        send_frame(1'b0, 1'b1, 16'd10, 64, 1'b1);
        check_frame("R8", 64, 1'b0);

        // R7: runt that ends before the length field
        send_frame(1'b1, 1'b1, 16'd0, 8, 1'b1);
        check_frame("R7", 8, 1'b1);

        // R9: reset in mid-frame, then bytes with no start marker
        clear_mon();
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #1;
            strip_en = 1'b1; in_valid = 1'b1; in_sof = (k == 0); in_eof = 1'b0;
            in_data = byte_at(k, 16'd10);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0;
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R9", "valid after reset", int'(out_valid), 0);
        send_frame(1'b1, 1'b1, 16'd10, 20, 1'b0);
        chk(mon_n == 0, "R9", "bytes without start marker", mon_n, 0);
        send_frame(1'b1, 1'b1, 16'd10, 64, 1'b1);
        check_frame("R9", 24, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule